// File: doc/BRIEF.md
# Interrupt Priority and Entry Sequencer

This block sits beside the instruction decoder of an 8-bit processor core and answers one question each time the decoder reaches an instruction boundary. The choices are to stop for a bus halt, to restart for a core reset, to enter one of three hardware interrupts, or to let the decoder fetch the next opcode. When an exception wins, the block runs the whole entry sequence. It marks the condition-code register to show how much state is saved, asks the external stack unit to push that state, raises the interrupt masks that the source calls for, and reads a 16-bit vector from the top page of memory into the program counter.

The decoder also hands the block its software exceptions: three software-interrupt levels and a wait-for-interrupt instruction. The wait instruction trims the condition codes with an immediate mask and stacks the full state. The block then parks with the bus released until a reset or an enabled interrupt arrives, and enters that source without stacking a second time. The register arithmetic, the stack engine and the memory sit outside the block. They are reached through request/acknowledge pairs.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst_n` is released, `cc_o` is 0x50 (both masks set), `ba`, `bs`, `push_req`, `mem_req`, `fetch_go` and `pc_load` are all low. Condition-code bit positions are E=7, F=6, I=4. A one-cycle `cc_wr` in normal running loads `cc_wdata` into `cc_o` on the next edge.
- R2: A boundary seen with `halt_n` low parks the block with `ba` and `bs` both high. This happens even when a core reset is also pending. When `halt_n` goes high again, the block arbitrates again without needing a new boundary strobe.
- R3: A boundary with `cpu_reset_n` low pulses `dp_clr`, sets I and F, pushes nothing, and loads the vector at 0xFFFE/0xFFFF. A reset entry also discards a latched NMI.
- R4: NMI is latched on a falling edge of `nmi_n`. A held-low level yields a single entry. NMI ignores both masks and beats the fast and normal interrupts. A new falling edge in the same cycle that a pending NMI is taken stays latched.
- R5: The fast interrupt (`firq_n` low) is taken only when F is clear. It clears E, pushes with mask 0x81, sets I and F, and uses vector 0xFFF6. It beats the normal interrupt.
- R6: The normal interrupt (`irq_n` low) is taken only when I is clear. It sets E, pushes with mask 0xFF, sets I alone, and uses vector 0xFFF8.
- R7: Software exceptions use `sw_kind`: 0 = SWI, 1 = SWI2, 2 = SWI3. Each sets E and pushes with mask 0xFF. SWI then sets I and F and uses 0xFFFA. SWI2 (0xFFF4) and SWI3 (0xFFF2) leave both masks unchanged.
- R8: Wait (`sw_kind` 3) writes `(cc & sw_imm) | 0x80` and pushes with mask 0xFF. It then holds `ba` and `bs` high until an enabled source arrives. It enters that source without a second push.
- R9: While an entry is in progress, `ba` is low and `bs` is high. During normal running both are low.
- R10: A vector is read with two handshakes, the high byte from address `{0xFF, lo}` first and then the low byte from `lo+1`. The address is held until acknowledged, and `pc_o` becomes `{high, low}` with a one-cycle `pc_load`.
- R11: A boundary with nothing eligible pulses `fetch_go` one cycle later and starts no push or memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| boundary_i | input | 1 | One-cycle strobe: decoder is at an instruction boundary |
| halt_n | input | 1 | Active-low bus halt request |
| cpu_reset_n | input | 1 | Active-low core reset request (taken at a boundary) |
| nmi_n | input | 1 | Active-low non-maskable interrupt, edge-latched |
| firq_n | input | 1 | Active-low fast interrupt, level |
| irq_n | input | 1 | Active-low normal interrupt, level |
| sw_valid | input | 1 | Decoder presents a software exception |
| sw_kind | input | 2 | 0 SWI, 1 SWI2, 2 SWI3, 3 wait-for-interrupt |
| sw_imm | input | 8 | AND mask applied to CC by the wait instruction |
| sw_ack | output | 1 | One-cycle acknowledge of `sw_valid` |
| cc_wr | input | 1 | Execution unit writes the condition codes |
| cc_wdata | input | 8 | Condition-code write value |
| cc_o | output | 8 | Current condition codes |
| dp_clr | output | 1 | One-cycle pulse: clear the direct-page register |
| fetch_go | output | 1 | One-cycle pulse: fetch the next opcode |
| push_req | output | 1 | Request to the stack unit, held until acknowledged |
| push_mask | output | 8 | Registers to push (0xFF full, 0x81 PC and CC) |
| push_ack | input | 1 | Stack unit finished the push |
| mem_req | output | 1 | Vector byte read request |
| mem_addr | output | 16 | Vector byte address |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read completed |
| pc_load | output | 1 | One-cycle pulse: load `pc_o` into the program counter |
| pc_o | output | 16 | Vector fetched by the last entry |
| ba | output | 1 | Bus-available status |
| bs | output | 1 | Bus-state status |

## Verification
Two events can meet in the same cycle. One is a fresh falling edge on `nmi_n`. The other is the entry that consumes the already-latched NMI. The bench provokes this by latching one NMI, releasing the pin, and then driving the pin low again on the same edge where the boundary strobe is sampled. It judges the result by requiring two complete NMI entries, and then a plain fetch on the third boundary. A second collision drives halt and core reset at the same boundary. The bench expects the parked bus status first, and then a reset entry as soon as halt lifts, with no new strobe.

// File: rtl/irq_entry_pkg.sv
// Shared encodings for the interrupt entry sequencer.
// Assumes an 8-bit condition-code register and a 16-bit program counter.
package irq_entry_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Condition-code bit positions used by the stack unit and the decoder
    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_I = 4;

    localparam logic [BYTE_W-1:0] CC_AT_RESET = 8'h50;
    localparam logic [BYTE_W-1:0] PUSH_ALL    = 8'hFF;
    localparam logic [BYTE_W-1:0] PUSH_FAST   = 8'h81;
    localparam logic [BYTE_W-1:0] BIT_E       = 8'h80;
    localparam logic [BYTE_W-1:0] BIT_IF      = 8'h50;
    localparam logic [BYTE_W-1:0] BIT_I       = 8'h10;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_RESET, SRC_NMI, SRC_FIRQ, SRC_IRQ,
        SRC_SWI, SRC_SWI2, SRC_SWI3
    } src_e;

    typedef enum logic [1:0] {
        SW_SWI = 2'd0, SW_SWI2 = 2'd1, SW_SWI3 = 2'd2, SW_WAIT = 2'd3
    } sw_kind_e;

    typedef enum logic [2:0] {
        ST_RUN, ST_HALT, ST_PUSH, ST_WAIT, ST_VEC
    } seq_state_e;

    // Low address byte of each source's vector inside the top page
    function automatic logic [BYTE_W-1:0] vec_low(src_e s);
        case (s)
            SRC_RESET: return 8'hFE;
            SRC_NMI:   return 8'hFC;
            SRC_SWI:   return 8'hFA;
            SRC_IRQ:   return 8'hF8;
            SRC_FIRQ:  return 8'hF6;
            SRC_SWI2:  return 8'hF4;
            SRC_SWI3:  return 8'hF2;
            default:   return 8'hFE;
        endcase
    endfunction

    // Mask bits each source raises once its state is saved
    function automatic logic [BYTE_W-1:0] mask_raise(src_e s);
        case (s)
            SRC_RESET, SRC_NMI, SRC_FIRQ, SRC_SWI: return BIT_IF;
            SRC_IRQ:                               return BIT_I;
            default:                               return 8'h00;
        endcase
    endfunction

    // Source named by a software exception kind
    function automatic src_e sw_source(sw_kind_e k);
        case (k)
            SW_SWI2: return SRC_SWI2;
            SW_SWI3: return SRC_SWI3;
            default: return SRC_SWI;
        endcase
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
// Falling-edge latch for the non-maskable interrupt pin.
// Assumes nmi_n is already synchronous to clk. A new edge in the
// same cycle as a clear keeps the latch set.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    logic prev_q;
    logic fall;

    // Edge detect against the pin level from the previous cycle
    assign fall = prev_q & ~nmi_n;

    // Track the pin and hold the pending flag until it is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            pending <= 1'b0;
        end else begin
            prev_q  <= nmi_n;
            pending <= (pending & ~take) | fall;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority pick among halt, reset, NMI, fast and normal
// interrupts. Purely combinational; the caller decides when it applies.
module irq_arbiter
    import irq_entry_pkg::*;
(
    input  logic halt_req,
    input  logic reset_req,
    input  logic nmi_pend,
    input  logic firq_req,
    input  logic irq_req,
    input  logic f_masked,
    input  logic i_masked,
    output logic halt_win,
    output src_e src
);
    // Highest-priority eligible source, or none for a plain fetch
    always_comb begin
        halt_win = 1'b0;
        src      = SRC_NONE;
        if (halt_req)                  halt_win = 1'b1;
        else if (reset_req)            src = SRC_RESET;
        else if (nmi_pend)             src = SRC_NMI;
        else if (firq_req && !f_masked) src = SRC_FIRQ;
        else if (irq_req && !i_masked)  src = SRC_IRQ;
    end
endmodule

// File: rtl/irq_vector_reader.sv
// Reads a big-endian vector word from the top memory page over a
// byte request/acknowledge port. High byte first, then low byte.
// Assumes the vector low byte given at start is even.
module irq_vector_reader
    import irq_entry_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VEC_PAGE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] lo_sel,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [WORD_W-1:0] vector
);
    typedef enum logic [1:0] {RD_IDLE, RD_HI, RD_LO} rd_e;

    rd_e               st;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Step through the two byte reads, capturing the high byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RD_IDLE;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            case (st)
                RD_IDLE: if (start) begin
                    lo_q <= lo_sel;
                    st   <= RD_HI;
                end
                RD_HI: if (mem_ack) begin
                    hi_q <= mem_rdata;
                    st   <= RD_LO;
                end
                RD_LO: if (mem_ack) st <= RD_IDLE;
                default: st <= RD_IDLE;
            endcase
        end
    end

    // Address and completion derived from the read phase
    always_comb begin
        mem_req  = (st != RD_IDLE);
        mem_addr = {VEC_PAGE, lo_q + {{(BYTE_W-1){1'b0}}, st == RD_LO}};
        done     = (st == RD_LO) && mem_ack;
        vector   = {hi_q, mem_rdata};
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Boundary arbitration and exception entry sequencing.
// Owns the condition codes. The decoder strobes boundary_i once per
// boundary and presents software exceptions only between boundaries.
// The stack unit pushes the registers named by push_mask, reading cc_o.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VEC_PAGE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              halt_n,
    input  logic              cpu_reset_n,
    input  logic              nmi_n,
    input  logic              firq_n,
    input  logic              irq_n,
    input  logic              sw_valid,
    input  logic [1:0]        sw_kind,
    input  logic [BYTE_W-1:0] sw_imm,
    output logic              sw_ack,
    input  logic              cc_wr,
    input  logic [BYTE_W-1:0] cc_wdata,
    output logic [BYTE_W-1:0] cc_o,
    output logic              dp_clr,
    output logic              fetch_go,
    output logic              push_req,
    output logic [BYTE_W-1:0] push_mask,
    input  logic              push_ack,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_o,
    output logic              ba,
    output logic              bs
);
    seq_state_e        st;
    src_e              cur_src;
    src_e              arb_src;
    sw_kind_e          kind;
    logic              redo_q;
    logic              wait_q;
    logic              vec_go;
    logic              halt_win;
    logic              nmi_pend;
    logic              nmi_take;
    logic              run_dec;
    logic              vec_done;
    logic [WORD_W-1:0] vec_word;
    logic [BYTE_W-1:0] vec_lo_q;

    assign kind = sw_kind_e'(sw_kind);

    // A decision is due on a boundary strobe or right after a halt lifts
    assign run_dec = (st == ST_RUN) && (boundary_i || redo_q);

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    irq_arbiter u_arb (
        .halt_req  (~halt_n && (st == ST_RUN)),
        .reset_req (~cpu_reset_n),
        .nmi_pend  (nmi_pend),
        .firq_req  (~firq_n),
        .irq_req   (~irq_n),
        .f_masked  (cc_o[CC_F]),
        .i_masked  (cc_o[CC_I]),
        .halt_win  (halt_win),
        .src       (arb_src)
    );

    // The latched NMI is consumed by an NMI or a reset entry
    assign nmi_take = ((run_dec && !halt_win) || (st == ST_WAIT)) &&
                      ((arb_src == SRC_NMI) || (arb_src == SRC_RESET));

    irq_vector_reader #(.VEC_PAGE(VEC_PAGE)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (vec_go),
        .lo_sel    (vec_lo_q),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .done      (vec_done),
        .vector    (vec_word)
    );

    // Main sequencer: arbitration, state save, mask update, vector load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_RUN;
            cc_o      <= CC_AT_RESET;
            cur_src   <= SRC_NONE;
            push_mask <= '0;
            redo_q    <= 1'b0;
            wait_q    <= 1'b0;
            vec_go    <= 1'b0;
            vec_lo_q  <= '0;
            fetch_go  <= 1'b0;
            dp_clr    <= 1'b0;
            sw_ack    <= 1'b0;
            pc_load   <= 1'b0;
            pc_o      <= '0;
        end else begin
            fetch_go <= 1'b0;
            dp_clr   <= 1'b0;
            sw_ack   <= 1'b0;
            pc_load  <= 1'b0;
            vec_go   <= 1'b0;
            case (st)
                ST_RUN: begin
                    redo_q <= 1'b0;
                    if (run_dec) begin
                        if (halt_win) begin
                            st <= ST_HALT;
                        end else begin
                            case (arb_src)
                                SRC_RESET: begin
                                    cc_o     <= cc_o | mask_raise(SRC_RESET);
                                    dp_clr   <= 1'b1;
                                    cur_src  <= SRC_RESET;
                                    vec_lo_q <= vec_low(SRC_RESET);
                                    vec_go   <= 1'b1;
                                    st       <= ST_VEC;
                                end
                                SRC_FIRQ: begin
                                    cc_o      <= cc_o & ~BIT_E;
                                    push_mask <= PUSH_FAST;
                                    cur_src   <= SRC_FIRQ;
                                    st        <= ST_PUSH;
                                end
                                SRC_NMI, SRC_IRQ: begin
                                    cc_o      <= cc_o | BIT_E;
                                    push_mask <= PUSH_ALL;
                                    cur_src   <= arb_src;
                                    st        <= ST_PUSH;
                                end
                                default: fetch_go <= 1'b1;
                            endcase
                        end
                    end else if (sw_valid) begin
                        sw_ack    <= 1'b1;
                        push_mask <= PUSH_ALL;
                        cur_src   <= sw_source(kind);
                        wait_q    <= (kind == SW_WAIT);
                        cc_o      <= ((kind == SW_WAIT) ? (cc_o & sw_imm) : cc_o) | BIT_E;
                        st        <= ST_PUSH;
                    end else if (cc_wr) begin
                        cc_o <= cc_wdata;
                    end
                end
                ST_PUSH: if (push_ack) begin
                    if (wait_q) begin
                        wait_q <= 1'b0;
                        st     <= ST_WAIT;
                    end else begin
                        cc_o     <= cc_o | mask_raise(cur_src);
                        vec_lo_q <= vec_low(cur_src);
                        vec_go   <= 1'b1;
                        st       <= ST_VEC;
                    end
                end
                ST_WAIT: if (arb_src != SRC_NONE) begin
                    cc_o     <= cc_o | mask_raise(arb_src);
                    dp_clr   <= (arb_src == SRC_RESET);
                    cur_src  <= arb_src;
                    vec_lo_q <= vec_low(arb_src);
                    vec_go   <= 1'b1;
                    st       <= ST_VEC;
                end
                ST_VEC: if (vec_done) begin
                    pc_o    <= vec_word;
                    pc_load <= 1'b1;
                    st      <= ST_RUN;
                end
                ST_HALT: if (halt_n) begin
                    redo_q <= 1'b1;
                    st     <= ST_RUN;
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    // Bus status and push request follow the sequencer state
    always_comb begin
        push_req = (st == ST_PUSH);
        ba       = (st == ST_HALT) || (st == ST_WAIT);
        bs       = (st != ST_RUN);
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Protocol and status checks for the entry sequencer, bound to its top.
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ba,
    input logic        bs,
    input logic        push_req,
    input logic        push_ack,
    input logic [7:0]  push_mask,
    input logic [7:0]  cc_o,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [15:0] mem_addr,
    input logic        fetch_go,
    input logic        pc_load,
    input logic        sw_ack
);
    // R9
    ba_implies_bs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba |-> bs);

    // R10
    vec_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[15:8] == 8'hFF));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    save_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> ((push_mask == 8'hFF && cc_o[7]) ||
                      (push_mask == 8'h81 && !cc_o[7])));

    // R8
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ack) |=> (push_req && $stable(push_mask)));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_go, pc_load, sw_ack}));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_irq_entry_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ba        (ba),
    .bs        (bs),
    .push_req  (push_req),
    .push_ack  (push_ack),
    .push_mask (push_mask),
    .cc_o      (cc_o),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .fetch_go  (fetch_go),
    .pc_load   (pc_load),
    .sw_ack    (sw_ack)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EV_FETCH = 1, EV_PUSH = 2, EV_MEM = 3, EV_PC = 4, EV_DP = 5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        boundary_i = 0, halt_n = 1, cpu_reset_n = 1;
    logic        nmi_n = 1, firq_n = 1, irq_n = 1;
    logic        sw_valid = 0;
    logic [1:0]  sw_kind = 0;
    logic [7:0]  sw_imm = 0;
    logic        sw_ack;
    logic        cc_wr = 0;
    logic [7:0]  cc_wdata = 0;
    logic [7:0]  cc_o;
    logic        dp_clr, fetch_go, push_req, push_ack = 0;
    logic [7:0]  push_mask;
    logic        mem_req, mem_ack = 0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 0;
    logic        pc_load;
    logic [15:0] pc_o;
    logic        ba, bs;

    int checks = 0;
    int errors = 0;
    int          q_kind[$];
    logic [15:0] q_data[$];
    string       q_req[$];

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .halt_n(halt_n),
        .cpu_reset_n(cpu_reset_n), .nmi_n(nmi_n), .firq_n(firq_n), .irq_n(irq_n),
        .sw_valid(sw_valid), .sw_kind(sw_kind), .sw_imm(sw_imm), .sw_ack(sw_ack),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata), .cc_o(cc_o), .dp_clr(dp_clr),
        .fetch_go(fetch_go), .push_req(push_req), .push_mask(push_mask),
        .push_ack(push_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc_load(pc_load), .pc_o(pc_o),
        .ba(ba), .bs(bs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory image of the vector page: every byte is its address xor 0xA5
    function automatic logic [7:0] mem_byte(logic [7:0] a);
        return a ^ 8'hA5;
    endfunction

    function automatic logic [15:0] vec_of(logic [7:0] lo);
        return {mem_byte(lo), mem_byte(lo + 8'd1)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int k, input logic [15:0] d, input string req);
        q_kind.push_back(k);
        q_data.push_back(d);
        q_req.push_back(req);
    endtask

    // Full entry: optional push, two vector reads, program counter load
    task automatic expect_entry(input bit pushes, input logic [7:0] cc_at_push,
                                input logic [7:0] mask, input logic [7:0] lo,
                                input string req);
        if (pushes) expect_ev(EV_PUSH, {cc_at_push, mask}, req);
        expect_ev(EV_MEM, {8'hFF, lo}, req);
        expect_ev(EV_MEM, {8'hFF, lo + 8'd1}, req);
        expect_ev(EV_PC, vec_of(lo), req);
    endtask

    // Monitor compares each observed event with the head of the queue
    task automatic observe(input int k, input logic [15:0] d);
        if (q_kind.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL unexpected event actual %0d:%h expected none", k, d);
        end else begin
            int          ek = q_kind.pop_front();
            logic [15:0] ed = q_data.pop_front();
            string       er = q_req.pop_front();
            check(ek == k && ed == d, er, {k[3:0], d[11:0]}, {ek[3:0], ed[11:0]});
        end
    endtask

    // Stack unit and memory models, plus the scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (dp_clr)   observe(EV_DP, 16'h0000);
            if (fetch_go) observe(EV_FETCH, 16'h0000);
            if (pc_load)  observe(EV_PC, pc_o);
            if (push_req && !push_ack) begin
                observe(EV_PUSH, {cc_o, push_mask});
                push_ack <= 1'b1;
            end else push_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                observe(EV_MEM, mem_addr);
                mem_rdata <= mem_byte(mem_addr[7:0]);
                mem_ack   <= 1'b1;
            end else mem_ack <= 1'b0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        boundary_i = 1;
        tick(1);
        boundary_i = 0;
    endtask

    task automatic cc_load(input logic [7:0] v);
        cc_wr = 1; cc_wdata = v;
        tick(1);
        cc_wr = 0;
        tick(1);
    endtask

    task automatic sw_issue(input logic [1:0] k, input logic [7:0] imm);
        sw_valid = 1; sw_kind = k; sw_imm = imm;
        tick(1);
        sw_valid = 0;
    endtask

    task automatic drain(input string req);
        tick(16);
        check(q_kind.size() == 0, req, 16'(q_kind.size()), 16'h0);
    endtask

    bit finished = 0;

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        check(cc_o == 8'h50, "R1 cc after reset", cc_o, 8'h50);
        check({ba, bs, push_req, mem_req, fetch_go, pc_load} == 0, "R1 idle outputs",
              {ba, bs, push_req, mem_req, fetch_go, pc_load}, 0);
        cc_load(8'h00);
        check(cc_o == 8'h00, "R1 cc write", cc_o, 8'h00);

        // R11 plain fetch
        expect_ev(EV_FETCH, 0, "R11 fetch");
        strobe();
        drain("R11 queue");

        // R6 normal interrupt, R9 status during entry
        irq_n = 0;
        expect_entry(1, 8'h80, 8'hFF, 8'hF8, "R6 irq entry");
        strobe();
        check(!ba && bs, "R9 entry status", {ba, bs}, 2'b01);
        drain("R6 queue");
        check(cc_o == 8'h90, "R6 masks after irq", cc_o, 8'h90);
        check(!ba && !bs, "R9 running status", {ba, bs}, 2'b00);
        // R6 masked by I
        expect_ev(EV_FETCH, 0, "R6 irq masked");
        strobe();
        drain("R6 masked queue");
        irq_n = 1;

        // R5 fast beats normal, clears E
        cc_load(8'h80);
        firq_n = 0; irq_n = 0;
        expect_entry(1, 8'h00, 8'h81, 8'hF6, "R5 firq entry");
        strobe();
        drain("R5 queue");
        check(cc_o == 8'h50, "R5 masks after firq", cc_o, 8'h50);
        irq_n = 1;
        // R5 masked by F
        cc_load(8'h40);
        expect_ev(EV_FETCH, 0, "R5 firq masked");
        strobe();
        drain("R5 masked queue");
        firq_n = 1;

        // R4 NMI beats fast, ignores masks, one entry per edge
        cc_load(8'h50);
        nmi_n = 0; firq_n = 0;
        tick(1);
        expect_entry(1, 8'hD0, 8'hFF, 8'hFC, "R4 nmi entry");
        strobe();
        drain("R4 queue");
        check(cc_o == 8'hD0, "R4 masks after nmi", cc_o, 8'hD0);
        expect_ev(EV_FETCH, 0, "R4 held level no re-entry");
        strobe();
        drain("R4 level queue");
        nmi_n = 1; firq_n = 1;

        // R7 software interrupts
        cc_load(8'h00);
        expect_entry(1, 8'h80, 8'hFF, 8'hFA, "R7 swi entry");
        sw_issue(2'd0, 8'h00);
        drain("R7 swi queue");
        check(cc_o == 8'hD0, "R7 swi masks", cc_o, 8'hD0);
        cc_load(8'h00);
        expect_entry(1, 8'h80, 8'hFF, 8'hF4, "R7 swi2 entry");
        sw_issue(2'd1, 8'h00);
        drain("R7 swi2 queue");
        check(cc_o == 8'h80, "R7 swi2 masks", cc_o, 8'h80);
        cc_load(8'h00);
        expect_entry(1, 8'h80, 8'hFF, 8'hF2, "R7 swi3 entry");
        sw_issue(2'd2, 8'h00);
        drain("R7 swi3 queue");
        check(cc_o == 8'h80, "R7 swi3 masks", cc_o, 8'h80);

        // R8 wait-for-interrupt
        cc_load(8'h5F);
        expect_ev(EV_PUSH, {8'h8F, 8'hFF}, "R8 wait push");
        sw_issue(2'd3, 8'hAF);
        drain("R8 push queue");
        check(ba && bs, "R8 parked status", {ba, bs}, 2'b11);
        check(cc_o == 8'h8F, "R8 cc trimmed", cc_o, 8'h8F);
        expect_entry(0, 8'h00, 8'h00, 8'hF8, "R8 wake entry");
        irq_n = 0;
        drain("R8 wake queue");
        check(cc_o == 8'h9F, "R8 cc after wake", cc_o, 8'h9F);
        irq_n = 1;

        // R2 halt beats reset; release re-arbitrates
        cc_load(8'h00);
        halt_n = 0; cpu_reset_n = 0;
        strobe();
        tick(3);
        check(ba && bs, "R2 halted status", {ba, bs}, 2'b11);
        check(q_kind.size() == 0 && !mem_req, "R2 nothing while halted", 16'(mem_req), 0);
        expect_ev(EV_DP, 0, "R2 reset after halt");
        expect_entry(0, 8'h00, 8'h00, 8'hFE, "R2 reset after halt");
        halt_n = 1;
        drain("R2 queue");
        check(cc_o == 8'h50, "R3 masks after reset", cc_o, 8'h50);
        cpu_reset_n = 1;

        // R3 reset discards a latched NMI
        tick(1);
        nmi_n = 0;
        tick(2);
        cpu_reset_n = 0;
        expect_ev(EV_DP, 0, "R3 dp clear");
        expect_entry(0, 8'h00, 8'h00, 8'hFE, "R3 reset entry");
        strobe();
        drain("R3 queue");
        cpu_reset_n = 1;
        tick(1);
        expect_ev(EV_FETCH, 0, "R3 nmi discarded");
        strobe();
        drain("R3 nmi queue");
        nmi_n = 1;

        // R4 new edge in the cycle a pending NMI is taken
        tick(1);
        nmi_n = 0;
        tick(1);
        nmi_n = 1;
        tick(1);
        expect_entry(1, 8'hD0, 8'hFF, 8'hFC, "R4 first nmi");
        nmi_n = 0;
        strobe();
        drain("R4 first queue");
        expect_entry(1, 8'hD0, 8'hFF, 8'hFC, "R4 second nmi kept");
        strobe();
        drain("R4 second queue");
        expect_ev(EV_FETCH, 0, "R4 no third nmi");
        strobe();
        drain("R4 third queue");
        nmi_n = 1;

        // R10 vector page on every read was checked through the events
        check(pc_o == vec_of(8'hFC), "R10 last vector value", pc_o, vec_of(8'hFC));

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule